// File: doc/BRIEF.md
# Tagged halfword FIFO bridge

This block sits between a 32-bit bus slave port and a pair of 18-bit-wide FIFOs that feed and drain a serial test engine. Every bus write is broken into two FIFO entries. Each entry carries a 16-bit payload, a flag that tells the consumer whether the payload is a command or plain data, and an even-parity bit. Every bus read takes two entries from the receive FIFO, checks both, and joins their payloads into one 32-bit word.

The bus side follows a classic strobe/acknowledge handshake. The master holds `bus_cyc` and `bus_stb` until it sees either `bus_ack` or `bus_err`. A request is refused with `bus_err`, and no FIFO entry is touched, when any of these holds:
- the address is unmapped or misaligned;
- the byte selects are partial;
- the send FIFO has fewer than two free slots;
- the receive FIFO holds fewer than two entries.

The consumer of the send FIFO and the producer of the receive FIFO connect through a plain pop/push port on the block's other side.

The FIFO storage inside is an ordinary synchronous FIFO with a show-ahead head.

Top module: `tagfifo_bridge`

## Requirements
- R1: A full-word write (`bus_sel` = 4'hF) to byte address 0x000, with at least two free send slots, pushes two entries. The entry holding `bus_wdat[15:0]` is pushed first and the entry holding `bus_wdat[31:16]` second. Both entries have bit 16 = 0. The write ends with `bus_ack`.
- R2: The same write to byte address 0x004 pushes the same two entries, but with bit 16 = 1 on both.
- R3: Every send entry has its payload in bits 15:0. Bit 17 is chosen so that bits 17:0 hold an even number of ones.
- R4: A full-word read of byte address 0x000 needs at least two entries in the receive FIFO. If both popped entries have even parity and bit 16 = 0, the read answers `bus_ack` with `bus_rdat` = {second payload, first payload}.
- R5: If either popped receive entry has odd parity over bits 17:0, or has bit 16 = 1, the read answers `bus_err`. Both entries are still consumed.
- R6: A write made while fewer than two send slots are free answers `bus_err` and pushes nothing.
- R7: A read made while fewer than two receive entries are present answers `bus_err` and pops nothing.
- R8: Each of the following answers `bus_err` and moves no FIFO entry: an address other than 0x000/0x004, an address with bits 1:0 nonzero, `bus_sel` other than 4'hF, or a read of 0x004.
- R9: Each access gets exactly one response, one cycle wide. `bus_ack` and `bus_err` are never high together. Counted from the first clock edge that sees the strobe, a refusal appears after that edge, and an acknowledge appears after the third edge.
- R10: While reset (`rst_n` = 0) is applied, `bus_ack`, `bus_err`, `snd_valid` and `rcv_full` are all low.
- R11: The receive FIFO holds `DEPTH` (1024) entries. `rcv_full` is high while it is full, and a `rcv_push` made while it is full is dropped.
- R12: `snd_valid` is high whenever the send FIFO is not empty, and `snd_entry` shows the oldest entry. A `snd_pop` made while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both bus and FIFO sides |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Bus strobe, held until a response |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 10 | Byte address (256 word locations) |
| bus_sel | input | 4 | Byte lane selects; only 4'hF is accepted |
| bus_wdat | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle successful completion |
| bus_err | output | 1 | One-cycle refusal or receive check failure |
| bus_rdat | output | 32 | Read data, valid with `bus_ack` |
| snd_pop | input | 1 | Consumer removes the head send entry |
| snd_valid | output | 1 | Send FIFO holds at least one entry |
| snd_entry | output | 18 | Head send entry {parity, flag, payload} |
| rcv_push | input | 1 | Producer adds an entry to the receive FIFO |
| rcv_entry | input | 18 | Receive entry {parity, flag, payload} |
| rcv_full | output | 1 | Receive FIFO is full |

## Verification
Some properties are checked on every cycle. Responses must be exclusive and one cycle wide. A refused request must not be followed by a push or pop. The second half of a write must be followed by an acknowledge. The send FIFO head must show even parity. The occupancy counts must stay bounded and must not move when a push meets a full FIFO. The exact entry contents, the halfword order, the flag value per address, and the reassembled read word can only be shown by the bench's scenarios. The same holds for the check that a refused access leaves the FIFO contents intact, and that a failed read still consumes its two entries.

// File: rtl/tagfifo_pkg.sv
package tagfifo_pkg;

  localparam int PAY_W   = 16;
  localparam int ENTRY_W = PAY_W + 2;

  // One FIFO slot: parity on top, command flag, then payload
  typedef struct packed {
    logic             par;
    logic             cmd;
    logic [PAY_W-1:0] pay;
  } entry_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WLO,
    PH_WHI,
    PH_RLO,
    PH_RHI
  } phase_t;

  // Parity bit that makes the whole 18-bit slot hold an even count of ones
  function automatic logic even_bit(input logic cmd, input logic [PAY_W-1:0] pay);
    return ^{cmd, pay};
  endfunction

  function automatic entry_t pack_entry(input logic cmd, input logic [PAY_W-1:0] pay);
    entry_t e;
    e.par = even_bit(cmd, pay);
    e.cmd = cmd;
    e.pay = pay;
    return e;
  endfunction

  // A receive slot is acceptable when parity is even and the flag is clear
  function automatic logic rcv_slot_ok(input entry_t e);
    return ((^{e.par, e.cmd, e.pay}) == 1'b0) && !e.cmd;
  endfunction

endpackage

// File: rtl/tagfifo_store.sv
module tagfifo_store #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           din,
  input  logic                       pop,
  output logic [WIDTH-1:0]           dout,
  output logic [$clog2(DEPTH):0]     count
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             empty, full;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R11
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(count));

  // R12
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (count == '0));

endmodule

// File: rtl/tagfifo_front.sv
module tagfifo_front
  import tagfifo_pkg::*;
#(
  parameter int ADR_W     = 10,
  parameter int DEPTH     = 1024,
  parameter int DATA_WORD = 0,
  parameter int CMD_WORD  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cyc,
  input  logic                    stb,
  input  logic                    we,
  input  logic [ADR_W-1:0]        adr,
  input  logic [3:0]              sel,
  input  logic [31:0]             wdat,
  output logic                    ack,
  output logic                    err,
  output logic [31:0]             rdat,
  output logic                    snd_push,
  output entry_t                  snd_wr,
  input  logic [$clog2(DEPTH):0]  snd_count,
  output logic                    rcv_pop,
  input  entry_t                  rcv_head,
  input  logic [$clog2(DEPTH):0]  rcv_count
);

  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int WI_W = ADR_W - 2;

  phase_t          phase;
  logic [31:0]     wbuf;
  logic            wcmd;
  entry_t          lo_q;

  logic [WI_W-1:0] word_idx;
  logic            aligned, hit_data, hit_cmd, full_sel;
  logic            room2, avail2;
  logic            req, wr_go, rd_go, rej;
  logic            pair_good;

  // Named internal events, used by the checks below
  logic            ev_push_lo, ev_push_hi, ev_pop_hi;

  assign word_idx = adr[ADR_W-1:2];
  assign aligned  = (adr[1:0] == 2'b00);
  assign hit_data = aligned && (word_idx == WI_W'(DATA_WORD));
  assign hit_cmd  = aligned && (word_idx == WI_W'(CMD_WORD));
  assign full_sel = &sel;

  assign room2  = (snd_count <= CW'(DEPTH - 2));
  assign avail2 = (rcv_count >= CW'(2));

  assign req   = cyc & stb & ~ack & ~err & (phase == PH_IDLE);
  assign wr_go = req &  we & full_sel & (hit_data | hit_cmd) & room2;
  assign rd_go = req & ~we & full_sel & hit_data & avail2;
  assign rej   = req & ~wr_go & ~rd_go;

  assign ev_push_lo = (phase == PH_WLO);
  assign ev_push_hi = (phase == PH_WHI);
  assign ev_pop_hi  = (phase == PH_RHI);

  assign snd_push = ev_push_lo | ev_push_hi;
  assign snd_wr   = pack_entry(wcmd, ev_push_lo ? wbuf[15:0] : wbuf[31:16]);
  assign rcv_pop  = (phase == PH_RLO) | ev_pop_hi;

  assign pair_good = rcv_slot_ok(lo_q) && rcv_slot_ok(rcv_head);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      wbuf  <= '0;
      wcmd  <= 1'b0;
      lo_q  <= '0;
      ack   <= 1'b0;
      err   <= 1'b0;
      rdat  <= '0;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (wr_go) begin
            phase <= PH_WLO;
            wbuf  <= wdat;
            wcmd  <= hit_cmd;
          end else if (rd_go) begin
            phase <= PH_RLO;
          end else if (rej) begin
            err <= 1'b1;
          end
        end
        PH_WLO: phase <= PH_WHI;
        PH_WHI: begin
          phase <= PH_IDLE;
          ack   <= 1'b1;
        end
        PH_RLO: begin
          lo_q  <= rcv_head;
          phase <= PH_RHI;
        end
        PH_RHI: begin
          phase <= PH_IDLE;
          if (pair_good) begin
            ack  <= 1'b1;
            rdat <= {rcv_head.pay, lo_q.pay};
          end else begin
            err  <= 1'b1;
            rdat <= '0;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R9
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && err));

  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || err) |=> !(ack || err));

  // R1
  pair_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_lo |=> (ev_push_hi && snd_push));

  // R1
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_hi |=> (ack && !err));

  // R8
  rej_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> (!snd_push && !rcv_pop && err));

endmodule

// File: rtl/tagfifo_bridge.sv
module tagfifo_bridge
  import tagfifo_pkg::*;
#(
  parameter int ADR_W = 10,
  parameter int DEPTH = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cyc,
  input  logic               bus_stb,
  input  logic               bus_we,
  input  logic [ADR_W-1:0]   bus_adr,
  input  logic [3:0]         bus_sel,
  input  logic [31:0]        bus_wdat,
  output logic               bus_ack,
  output logic               bus_err,
  output logic [31:0]        bus_rdat,
  input  logic               snd_pop,
  output logic               snd_valid,
  output logic [17:0]        snd_entry,
  input  logic               rcv_push,
  input  logic [17:0]        rcv_entry,
  output logic               rcv_full
);

  localparam int CW = $clog2(DEPTH) + 1;

  logic          f_push, f_pop;
  entry_t        f_wr, rcv_head;
  logic [17:0]   rcv_head_raw;
  logic [CW-1:0] snd_cnt, rcv_cnt;

  assign rcv_head  = entry_t'(rcv_head_raw);
  assign snd_valid = (snd_cnt != '0);
  assign rcv_full  = (rcv_cnt == CW'(DEPTH));

  tagfifo_front #(
    .ADR_W     (ADR_W),
    .DEPTH     (DEPTH),
    .DATA_WORD (0),
    .CMD_WORD  (1)
  ) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc       (bus_cyc),
    .stb       (bus_stb),
    .we        (bus_we),
    .adr       (bus_adr),
    .sel       (bus_sel),
    .wdat      (bus_wdat),
    .ack       (bus_ack),
    .err       (bus_err),
    .rdat      (bus_rdat),
    .snd_push  (f_push),
    .snd_wr    (f_wr),
    .snd_count (snd_cnt),
    .rcv_pop   (f_pop),
    .rcv_head  (rcv_head),
    .rcv_count (rcv_cnt)
  );

  tagfifo_store #(
    .WIDTH (ENTRY_W),
    .DEPTH (DEPTH)
  ) u_snd (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (f_push),
    .din   (f_wr),
    .pop   (snd_pop),
    .dout  (snd_entry),
    .count (snd_cnt)
  );

  tagfifo_store #(
    .WIDTH (ENTRY_W),
    .DEPTH (DEPTH)
  ) u_rcv (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rcv_push),
    .din   (rcv_entry),
    .pop   (f_pop),
    .dout  (rcv_head_raw),
    .count (rcv_cnt)
  );

  // R3
  snd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid |-> ((^snd_entry) == 1'b0));

endmodule

// File: tb/tagfifo_bridge_bench.sv
module tagfifo_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_cyc, bus_stb, bus_we;
  logic [9:0]  bus_adr;
  logic [3:0]  bus_sel;
  logic [31:0] bus_wdat;
  logic        bus_ack, bus_err;
  logic [31:0] bus_rdat;
  logic        snd_pop, snd_valid;
  logic [17:0] snd_entry;
  logic        rcv_push;
  logic [17:0] rcv_entry;
  logic        rcv_full;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagfifo_bridge #(.ADR_W(10), .DEPTH(DEPTH)) u_tagfifo_bridge (
    .clk(clk), .rst_n(rst_n),
    .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_sel(bus_sel), .bus_wdat(bus_wdat),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdat(bus_rdat),
    .snd_pop(snd_pop), .snd_valid(snd_valid), .snd_entry(snd_entry),
    .rcv_push(rcv_push), .rcv_entry(rcv_entry), .rcv_full(rcv_full)
  );

  // Expected slot: parity set when flag+payload hold an odd number of ones
  function automatic logic [17:0] slot(input logic flag, input logic [15:0] pay);
    logic p;
    p = ($countones({flag, pay}) % 2) == 1;
    return {p, flag, pay};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [9:0] adr, input logic [3:0] sel,
                      input logic [31:0] wd, output logic a, output logic e,
                      output logic [31:0] rd, output int lat);
    @(negedge clk);
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we;
    bus_adr = adr;  bus_sel = sel;  bus_wdat = wd;
    lat = 0; a = 1'b0; e = 1'b0; rd = '0;
    while (lat < 40) begin
      @(negedge clk);
      lat++;
      if (bus_ack || bus_err) begin
        a = bus_ack; e = bus_err; rd = bus_rdat;
        break;
      end
    end
    bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic pop_one(output logic v, output logic [17:0] ent);
    @(negedge clk);
    v = snd_valid; ent = snd_entry;
    snd_pop = 1'b1;
    @(negedge clk);
    snd_pop = 1'b0;
  endtask

  task automatic push_rcv(input logic [17:0] ent);
    @(negedge clk);
    rcv_push = 1'b1; rcv_entry = ent;
    @(negedge clk);
    rcv_push = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    bus_cyc = 0; bus_stb = 0; bus_we = 0; bus_adr = '0; bus_sel = '0; bus_wdat = '0;
    snd_pop = 0; rcv_push = 0; rcv_entry = '0;
    repeat (3) @(negedge clk);
    chk("R10 ack/err in reset", {30'd0, bus_ack, bus_err}, 32'd0);
    chk("R10 snd_valid/rcv_full in reset", {30'd0, snd_valid, rcv_full}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_empty_pop;
    logic v; logic [17:0] e;
    pop_one(v, e);
    @(negedge clk);
    chk("R12 pop on empty leaves it empty", {31'd0, snd_valid}, 32'd0);
  endtask

  task automatic t_write_data;
    logic a, e, v; logic [31:0] rd; int lat; logic [17:0] ent;
    xfer(1'b1, 10'h000, 4'hF, 32'hA5C3_1234, a, e, rd, lat);
    chk("R1 data write ack", {30'd0, a, e}, 32'd2);
    chk("R9 ack latency", lat, 3);
    pop_one(v, ent);
    chk("R12 valid with entries", {31'd0, v}, 32'd1);
    chk("R1 R3 low half first", {14'd0, ent}, {14'd0, slot(1'b0, 16'h1234)});
    pop_one(v, ent);
    chk("R1 R3 high half second", {14'd0, ent}, {14'd0, slot(1'b0, 16'hA5C3)});
    @(negedge clk);
    chk("R12 empty after two pops", {31'd0, snd_valid}, 32'd0);
  endtask

  task automatic t_write_cmd;
    logic a, e, v; logic [31:0] rd; int lat; logic [17:0] ent;
    xfer(1'b1, 10'h004, 4'hF, 32'h8001_00FE, a, e, rd, lat);
    chk("R2 command write ack", {30'd0, a, e}, 32'd2);
    pop_one(v, ent);
    chk("R2 R3 command low", {14'd0, ent}, {14'd0, slot(1'b1, 16'h00FE)});
    pop_one(v, ent);
    chk("R2 R3 command high", {14'd0, ent}, {14'd0, slot(1'b1, 16'h8001)});
  endtask

  task automatic t_read_ok;
    logic a, e; logic [31:0] rd; int lat;
    push_rcv(slot(1'b0, 16'hBEEF));
    push_rcv(slot(1'b0, 16'h1357));
    xfer(1'b0, 10'h000, 4'hF, '0, a, e, rd, lat);
    chk("R4 read ack", {30'd0, a, e}, 32'd2);
    chk("R4 read word", rd, 32'h1357_BEEF);
    chk("R9 read latency", lat, 3);
  endtask

  task automatic t_read_bad;
    logic a, e; logic [31:0] rd; int lat;
    push_rcv(slot(1'b0, 16'h0F0F) ^ 18'h20000);
    push_rcv(slot(1'b0, 16'h2222));
    xfer(1'b0, 10'h000, 4'hF, '0, a, e, rd, lat);
    chk("R5 parity mismatch err", {30'd0, a, e}, 32'd1);
    xfer(1'b0, 10'h000, 4'hF, '0, a, e, rd, lat);
    chk("R5 bad pair consumed", {30'd0, a, e}, 32'd1);
    push_rcv(slot(1'b0, 16'h4444));
    push_rcv(slot(1'b1, 16'h5555));
    xfer(1'b0, 10'h000, 4'hF, '0, a, e, rd, lat);
    chk("R5 flagged receive entry err", {30'd0, a, e}, 32'd1);
  endtask

  task automatic t_read_short;
    logic a, e; logic [31:0] rd; int lat;
    push_rcv(slot(1'b0, 16'hAAAA));
    xfer(1'b0, 10'h000, 4'hF, '0, a, e, rd, lat);
    chk("R7 short read err", {30'd0, a, e}, 32'd1);
    chk("R9 err latency", lat, 1);
    push_rcv(slot(1'b0, 16'hCCCC));
    xfer(1'b0, 10'h000, 4'hF, '0, a, e, rd, lat);
    chk("R7 entry kept after refusal", rd, 32'hCCCC_AAAA);
  endtask

  task automatic t_bad_access;
    logic a, e, v; logic [31:0] rd; int lat; logic [17:0] ent;
    xfer(1'b1, 10'h008, 4'hF, 32'h1111_1111, a, e, rd, lat);
    chk("R8 unmapped write err", {30'd0, a, e}, 32'd1);
    xfer(1'b1, 10'h001, 4'hF, 32'h2222_2222, a, e, rd, lat);
    chk("R8 misaligned write err", {30'd0, a, e}, 32'd1);
    xfer(1'b1, 10'h000, 4'h3, 32'h3333_3333, a, e, rd, lat);
    chk("R8 partial select err", {30'd0, a, e}, 32'd1);
    push_rcv(slot(1'b0, 16'h0001));
    push_rcv(slot(1'b0, 16'h0002));
    xfer(1'b0, 10'h004, 4'hF, '0, a, e, rd, lat);
    chk("R8 read of command address err", {30'd0, a, e}, 32'd1);
    @(negedge clk);
    chk("R8 nothing pushed", {31'd0, snd_valid}, 32'd0);
    xfer(1'b0, 10'h000, 4'hF, '0, a, e, rd, lat);
    chk("R8 receive entries untouched", rd, 32'h0002_0001);
    xfer(1'b1, 10'h000, 4'hF, 32'h7777_6666, a, e, rd, lat);
    pop_one(v, ent);
    chk("R8 next good write intact", {14'd0, ent}, {14'd0, slot(1'b0, 16'h6666)});
    pop_one(v, ent);
  endtask

  task automatic t_fill_send;
    logic a, e, v; logic [31:0] rd; int lat; logic [17:0] ent;
    int acks = 0; int bad = 0; int got = 0;
    for (int i = 0; i < DEPTH/2; i++) begin
      xfer(1'b1, 10'h000, 4'hF, {16'(2*i+1), 16'(2*i)}, a, e, rd, lat);
      if (a) acks++;
    end
    chk("R1 all fill writes acked", acks, DEPTH/2);
    xfer(1'b1, 10'h000, 4'hF, 32'hDEAD_BEEF, a, e, rd, lat);
    chk("R6 write to full FIFO err", {30'd0, a, e}, 32'd1);
    for (int k = 0; k < DEPTH + 4; k++) begin
      pop_one(v, ent);
      if (v) begin
        if (ent !== slot(1'b0, 16'(got))) bad++;
        got++;
      end
    end
    chk("R6 entry count after refusal", got, DEPTH);
    chk("R6 R12 entry order", bad, 0);
  endtask

  task automatic t_fill_rcv;
    logic a, e; logic [31:0] rd; int lat; int bad = 0;
    for (int k = 0; k < DEPTH; k++) push_rcv(slot(1'b0, 16'(k)));
    chk("R11 full flag at depth", {31'd0, rcv_full}, 32'd1);
    push_rcv(slot(1'b0, 16'hFFFF));
    for (int i = 0; i < DEPTH/2; i++) begin
      xfer(1'b0, 10'h000, 4'hF, '0, a, e, rd, lat);
      if (!a || rd !== {16'(2*i+1), 16'(2*i)}) bad++;
    end
    chk("R11 R4 drained words", bad, 0);
    xfer(1'b0, 10'h000, 4'hF, '0, a, e, rd, lat);
    chk("R11 overflow push dropped", {30'd0, a, e}, 32'd1);
    chk("R11 full flag clear", {31'd0, rcv_full}, 32'd0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_empty_pop();
    t_write_data();
    t_write_cmd();
    t_read_ok();
    t_read_bad();
    t_read_short();
    t_bad_access();
    t_fill_send();
    t_fill_rcv();
    summary();
    $finish;
  end

endmodule